// File: doc/BRIEF.md
# Per-Pin Asynchronous Serial Engine

This block is a serial engine that sits behind one I/O pin. A 32-bit configuration word picks its mode: asynchronous transmit, asynchronous receive, or off. A second 32-bit timing word sets the length of one bit, counted in system clocks, and the number of data bits in a character.

In transmit mode the host writes a character. The engine then sends a low start bit, the data bits LSB first and a high stop bit. The result always goes out on the engine's own pin, and the line idles high.

In receive mode the engine watches a single serial source, `rx_src`. An input selector outside the block resolves that source. It may be this pin, a neighbouring pin, or an inverted copy of either. Because of this, several engines running at different bit periods can listen to one line that another pin is driving. The engine finds the falling edge of a start bit and samples each bit in the middle of its period. It then presents the character right-aligned and raises a ready flag, which the host clears by reading. While the enable input is low, the whole engine is held in reset.

Top module: `uart_pin_engine`

## Requirements
- R1: The mode field is configuration bits [5:1]. Code 5'b11110 selects transmit and code 5'b11111 selects receive. Any other code leaves the engine idle: it never becomes busy, never drives the pin and never receives.
- R2: `pin_oe` is high only when `en` is high, the mode is transmit and the output-control field, bits [7:6], equals 2'b01. `pin_out` is high whenever no frame is in progress.
- R3: The bit period is timing bits [31:16], in clocks, and must be at least 2. The character length is timing bits [4:0] plus one, giving 1 to 32 bits.
- R4: A frame starts on the clock edge that accepts a write. It is one period of low start bit, then the data bits LSB first with one period each, then one period of high stop bit.
- R5: `tx_busy` is high from the accepting edge until the end of the stop bit, exactly (length+2)*period cycles. A write while busy is ignored.
- R6: A write strobe in any mode other than transmit is ignored: no frame, busy stays low.
- R7: In receive mode, a complete character on `rx_src` appears right-aligned on `rx_data` (the first bit received lands in bit 0) with `rx_ready` set.
- R8: A start bit that is no longer low at its middle is discarded as a glitch and yields no character.
- R9: With `rx_rd` high, `rx_ready` is low on the next cycle unless a new character completes. `rx_data` holds its value until the next character completes.
- R10: While `en` is low, the transmitter is idle, `rx_ready` is low and `pin_oe` is low.
- R11: A character whose stop bit is sampled low is dropped, and `rx_ready` does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Enable; low holds the engine in reset |
| cfg_word | input | 32 | Configuration word (mode, output control) |
| timing_word | input | 32 | Bit period [31:16], length-1 [4:0] |
| rx_src | input | 1 | Resolved serial input from the selector |
| tx_wr | input | 1 | Host write strobe for a transmit character |
| tx_data | input | 32 | Character to send, right-aligned |
| rx_rd | input | 1 | Host read strobe; clears ready |
| pin_out | output | 1 | Serial output to this engine's own pin |
| pin_oe | output | 1 | Output enable for the pin |
| tx_busy | output | 1 | Transmit frame in progress |
| rx_ready | output | 1 | Received character available |
| rx_data | output | 32 | Received character, right-aligned |

## Verification
The assertions take for granted that the configuration and timing words only change while `en` is low, and that the bit period is never below two clocks. The stimulus meets this by changing words only inside a reconfigure task that first drops `en`. The properties on data stability and busy also assume the mode does not switch under a running frame. The bench only ever drives `rx_src` with whole bit periods of the programmed length. The one exception is the deliberate one-cycle glitch, which is kept shorter than half a period.

// File: rtl/uart_pin_pkg.sv
package uart_pin_pkg;
  localparam int CFG_W      = 32;
  localparam int MAX_CHAR   = 32;
  localparam int PERIOD_W   = 16;
  localparam int LEN_FIELD  = 5;
  localparam int LEN_W      = LEN_FIELD + 1;
  localparam int MODE_LSB   = 1;
  localparam int MODE_W     = 5;
  localparam int TT_LSB     = 6;

  localparam logic [MODE_W-1:0] MODE_TX = 5'b11110;
  localparam logic [MODE_W-1:0] MODE_RX = 5'b11111;
  localparam logic [1:0]        TT_DRIVE = 2'b01;

  function automatic logic [MODE_W-1:0] mode_of(input logic [CFG_W-1:0] c);
    return c[MODE_LSB +: MODE_W];
  endfunction

  function automatic logic [1:0] tt_of(input logic [CFG_W-1:0] c);
    return c[TT_LSB +: 2];
  endfunction

  function automatic logic [PERIOD_W-1:0] period_of(input logic [CFG_W-1:0] t);
    return t[CFG_W-1 -: PERIOD_W];
  endfunction

  function automatic logic [LEN_W-1:0] char_len_of(input logic [CFG_W-1:0] t);
    return {1'b0, t[LEN_FIELD-1:0]} + LEN_W'(1);
  endfunction

  function automatic logic [MAX_CHAR-1:0] align_rx(input logic [MAX_CHAR-1:0] sh,
                                                   input logic [LEN_W-1:0] len);
    return sh >> (MAX_CHAR - int'(len));
  endfunction
endpackage

// File: rtl/uart_pin_tx.sv
module uart_pin_tx
  import uart_pin_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic [PERIOD_W-1:0] period,
  input  logic [LEN_W-1:0]    char_len,
  input  logic                wr,
  input  logic [MAX_CHAR-1:0] data,
  output logic                line,
  output logic                busy,
  output logic                accept
);
  typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
  tx_state_t             state;
  logic [PERIOD_W-1:0]   cnt;
  logic [LEN_W-1:0]      bit_idx;
  logic [MAX_CHAR-1:0]   shreg;
  logic                  tick;

  assign accept = active && wr && (state == TX_IDLE);
  assign tick   = (cnt == '0);
  assign busy   = (state != TX_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= TX_IDLE; cnt <= '0; bit_idx <= '0; shreg <= '0; line <= 1'b1;
    end else if (!active) begin
      state <= TX_IDLE; cnt <= '0; bit_idx <= '0; line <= 1'b1;
    end else begin
      case (state)
        TX_IDLE: if (accept) begin
          shreg <= data; line <= 1'b0; cnt <= period - PERIOD_W'(1); state <= TX_START;
        end
        TX_START: if (tick) begin
          line <= shreg[0]; bit_idx <= '0; cnt <= period - PERIOD_W'(1); state <= TX_DATA;
        end else cnt <= cnt - PERIOD_W'(1);
        TX_DATA: if (tick) begin
          cnt <= period - PERIOD_W'(1);
          if (bit_idx == char_len - LEN_W'(1)) begin
            line <= 1'b1; state <= TX_STOP;
          end else begin
            line <= shreg[1]; shreg <= shreg >> 1; bit_idx <= bit_idx + LEN_W'(1);
          end
        end else cnt <= cnt - PERIOD_W'(1);
        TX_STOP: if (tick) state <= TX_IDLE;
                 else cnt <= cnt - PERIOD_W'(1);
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_pin_rx.sv
module uart_pin_rx
  import uart_pin_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active,
  input  logic [PERIOD_W-1:0] period,
  input  logic [LEN_W-1:0]    char_len,
  input  logic                src,
  input  logic                rd,
  output logic                ready,
  output logic [MAX_CHAR-1:0] data,
  output logic                done,
  output logic                fall_seen
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
  rx_state_t             state;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                  cur, prev;
  logic [PERIOD_W-1:0]   cnt;
  logic [LEN_W-1:0]      bit_idx;
  logic [MAX_CHAR-1:0]   shreg;
  logic                  tick;

  assign cur       = sync_q[SYNC_STAGES-1];
  assign tick      = (cnt == '0);
  assign fall_seen = active && (state == RX_IDLE) && prev && !cur;
  assign done      = active && (state == RX_STOP) && tick && cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1; prev <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], src};
      prev   <= cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= RX_IDLE; cnt <= '0; bit_idx <= '0; shreg <= '0;
    end else if (!active) begin
      state <= RX_IDLE; cnt <= '0; bit_idx <= '0;
    end else begin
      case (state)
        RX_IDLE: if (fall_seen) begin
          cnt <= (period >> 1) - PERIOD_W'(1); state <= RX_START;
        end
        RX_START: if (tick) begin
          if (cur) state <= RX_IDLE;
          else begin cnt <= period - PERIOD_W'(1); bit_idx <= '0; state <= RX_DATA; end
        end else cnt <= cnt - PERIOD_W'(1);
        RX_DATA: if (tick) begin
          shreg <= {cur, shreg[MAX_CHAR-1:1]};
          cnt   <= period - PERIOD_W'(1);
          if (bit_idx == char_len - LEN_W'(1)) state <= RX_STOP;
          else bit_idx <= bit_idx + LEN_W'(1);
        end else cnt <= cnt - PERIOD_W'(1);
        RX_STOP: if (tick) state <= RX_IDLE;
                 else cnt <= cnt - PERIOD_W'(1);
        default: state <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0; data <= '0;
    end else if (!active) begin
      ready <= 1'b0;
    end else if (done) begin
      ready <= 1'b1; data <= align_rx(shreg, char_len);
    end else if (rd) begin
      ready <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_pin_engine.sv
module uart_pin_engine
  import uart_pin_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [CFG_W-1:0]    cfg_word,
  input  logic [CFG_W-1:0]    timing_word,
  input  logic                rx_src,
  input  logic                tx_wr,
  input  logic [MAX_CHAR-1:0] tx_data,
  input  logic                rx_rd,
  output logic                pin_out,
  output logic                pin_oe,
  output logic                tx_busy,
  output logic                rx_ready,
  output logic [MAX_CHAR-1:0] rx_data
);
  logic                tx_on, rx_on;
  logic [PERIOD_W-1:0] period;
  logic [LEN_W-1:0]    char_len;
  logic                tx_accept, rx_done, rx_fall;

  assign tx_on    = en && (mode_of(cfg_word) == MODE_TX);
  assign rx_on    = en && (mode_of(cfg_word) == MODE_RX);
  assign period   = period_of(timing_word);
  assign char_len = char_len_of(timing_word);
  assign pin_oe   = tx_on && (tt_of(cfg_word) == TT_DRIVE);

  uart_pin_tx u_tx (
    .clk(clk), .rst_n(rst_n), .active(tx_on), .period(period), .char_len(char_len),
    .wr(tx_wr), .data(tx_data), .line(pin_out), .busy(tx_busy), .accept(tx_accept)
  );

  uart_pin_rx #(.SYNC_STAGES(2)) u_rx (
    .clk(clk), .rst_n(rst_n), .active(rx_on), .period(period), .char_len(char_len),
    .src(rx_src), .rd(rx_rd), .ready(rx_ready), .data(rx_data),
    .done(rx_done), .fall_seen(rx_fall)
  );
endmodule

// File: rtl/uart_pin_engine_chk.sv
module uart_pin_engine_chk
  import uart_pin_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                en,
  input logic                tx_wr,
  input logic                rx_rd,
  input logic                pin_out,
  input logic                tx_busy,
  input logic                rx_ready,
  input logic [MAX_CHAR-1:0] rx_data,
  input logic                tx_on,
  input logic                rx_on,
  input logic                tx_accept,
  input logic                rx_done
);
  AST_LINE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> pin_out); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> (tx_busy && !pin_out)); // R4
  AST_BUSY_ONLY_TX: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !$rose(tx_busy)) |-> $past(tx_on)); // R6
  AST_NO_ACCEPT_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> !tx_accept); // R5
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> rx_ready); // R7
  AST_READY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && rx_rd && !rx_done) |=> !rx_ready); // R9
  AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_done && rx_on) |=> $stable(rx_data)); // R9
  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tx_busy && !rx_ready)); // R10
  AST_NO_RX_OUTSIDE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_on |-> !rx_done); // R1
endmodule

bind uart_pin_engine uart_pin_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tx_wr(tx_wr), .rx_rd(rx_rd),
  .pin_out(pin_out), .tx_busy(tx_busy), .rx_ready(rx_ready), .rx_data(rx_data),
  .tx_on(tx_on), .rx_on(rx_on), .tx_accept(tx_accept), .rx_done(rx_done)
);

// File: tb/test_uart_pin_engine.sv
module test_uart_pin_engine;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic clk = 0, rst_n = 0, en = 0, rx_src = 1, tx_wr = 0, rx_rd = 0;
  logic [31:0] cfg_word = 0, timing_word = 0, tx_data = 0;
  logic pin_out, pin_oe, tx_busy, rx_ready;
  logic [31:0] rx_data;

  int n_tests = 0, n_fail = 0;
  int cur_p = 8, cur_len = 8;
  bit auto_read = 1;
  logic [31:0] tx_q[$];
  logic [31:0] rx_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_pin_engine i_uart_pin_engine (
    .clk(clk), .rst_n(rst_n), .en(en), .cfg_word(cfg_word), .timing_word(timing_word),
    .rx_src(rx_src), .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd),
    .pin_out(pin_out), .pin_oe(pin_oe), .tx_busy(tx_busy),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input logic [1:0] tt, input logic [4:0] mode);
    return {24'b0, tt, mode, 1'b0};
  endfunction

  function automatic logic [31:0] mk_tim(input int p, input int len);
    return {p[15:0], 11'b0, 5'(len - 1)};
  endfunction

  function automatic logic [31:0] mask_of(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'h1 << len) - 1);
  endfunction

  task automatic reconfig(input logic [31:0] c, input int p, input int len);
    @(negedge clk); en = 0;
    repeat (2) @(negedge clk);
    cfg_word = c; timing_word = mk_tim(p, len); cur_p = p; cur_len = len;
    en = 1;
    @(negedge clk);
  endtask

  // transmit driver: pushes the expected character, checks busy length
  task automatic send_tx(input logic [31:0] v, input bit expect_frame);
    int busy_cnt;
    if (expect_frame) tx_q.push_back(v & mask_of(cur_len));
    tx_data = v; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    busy_cnt = 0;
    while (tx_busy && busy_cnt < 100000) begin busy_cnt++; @(negedge clk); end
    if (expect_frame) check("R5 busy length", busy_cnt, (cur_len + 2) * cur_p);
  endtask

  // transmit monitor: decodes the pin line mid-bit
  initial begin
    logic prev_l;
    logic [31:0] got;
    bit ok_stop;
    prev_l = 1;
    forever begin
      @(negedge clk);
      if (pin_oe && !pin_out && prev_l) begin
        repeat (cur_p / 2) @(negedge clk);
        check("R4 start mid low", pin_out, 0);
        got = 0;
        for (int i = 0; i < cur_len; i++) begin
          repeat (cur_p) @(negedge clk);
          got[i] = pin_out;
        end
        repeat (cur_p) @(negedge clk);
        ok_stop = pin_out;
        check("R4 stop high", ok_stop, 1);
        if (tx_q.size() == 0) check("R4 unexpected frame", got, 32'hDEAD_BEEF);
        else check("R4 tx char", got, tx_q.pop_front());
      end
      prev_l = pin_out;
    end
  end

  // receive driver: pushes expected and drives the serial waveform
  task automatic send_rx(input logic [31:0] v, input bit good_stop, input bit expect_char);
    if (expect_char) rx_q.push_back(v & mask_of(cur_len));
    @(negedge clk);
    rx_src = 0; repeat (cur_p) @(negedge clk);
    for (int i = 0; i < cur_len; i++) begin rx_src = v[i]; repeat (cur_p) @(negedge clk); end
    rx_src = good_stop; repeat (cur_p) @(negedge clk);
    rx_src = 1; repeat (cur_p) @(negedge clk);
  endtask

  // receive monitor: pops and compares, reads to clear
  initial begin
    forever begin
      @(negedge clk);
      if (rx_ready && auto_read) begin
        if (rx_q.size() == 0) check("R7 unexpected char", rx_data, 32'hDEAD_BEEF);
        else check("R7 rx char", rx_data, rx_q.pop_front());
        rx_rd = 1;
        @(negedge clk); rx_rd = 0;
        check("R9 ready cleared by read", rx_ready, 0);
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_fail++; n_tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset oe", pin_oe, 0);
    check("R10 reset busy", tx_busy, 0);
    check("R10 reset ready", rx_ready, 0);
    check("R2 reset line high", pin_out, 1);

    // transmit, 8-bit, period 8
    reconfig(mk_cfg(2'b01, 5'b11110), 8, 8);
    check("R2 oe in drive tx", pin_oe, 1);
    tx_data = 32'hA5; tx_wr = 1; tx_q.push_back(32'hA5);
    @(negedge clk); tx_wr = 0;
    check("R5 busy after write", tx_busy, 1);
    check("R4 start low after write", pin_out, 0);
    while (tx_busy) @(negedge clk);
    send_tx(32'h00, 1);
    send_tx(32'hFF, 1);
    send_tx(32'h3C, 1);

    // write while busy is ignored
    tx_data = 32'h5A; tx_wr = 1; tx_q.push_back(32'h5A);
    @(negedge clk); tx_wr = 0;
    repeat (20) @(negedge clk);
    tx_data = 32'h11; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    while (tx_busy) @(negedge clk);
    repeat (30) @(negedge clk);
    check("R5 write while busy ignored", tx_busy, 0);
    check("R5 queue drained", tx_q.size(), 0);

    // 5-bit characters, period 10 (R3)
    reconfig(mk_cfg(2'b01, 5'b11110), 10, 5);
    send_tx(32'h13, 1);
    send_tx(32'hEE, 1);
    repeat (5) @(negedge clk);
    check("R3 short chars drained", tx_q.size(), 0);

    // transmit without output drive
    reconfig(mk_cfg(2'b00, 5'b11110), 8, 8);
    tx_data = 32'h81; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    check("R2 no oe with tt 00", pin_oe, 0);
    while (tx_busy) @(negedge clk);

    // idle mode code
    reconfig(mk_cfg(2'b01, 5'b00000), 8, 8);
    send_tx(32'h42, 0);
    check("R1 idle mode no busy", tx_busy, 0);
    check("R1 idle mode no oe", pin_oe, 0);

    // receive
    reconfig(mk_cfg(2'b00, 5'b11111), 8, 8);
    tx_data = 32'h99; tx_wr = 1;
    @(negedge clk); tx_wr = 0;
    check("R6 write in rx mode no busy", tx_busy, 0);
    check("R6 write in rx mode line high", pin_out, 1);
    send_rx(32'hC3, 1, 1);
    send_rx(32'h5E, 1, 1);
    send_rx(32'h01, 1, 1);
    reconfig(mk_cfg(2'b00, 5'b11111), 8, 5);
    send_rx(32'h0B, 1, 1);
    reconfig(mk_cfg(2'b00, 5'b11111), 6, 8);
    send_rx(32'h96, 1, 1);
    repeat (10) @(negedge clk);
    check("R7 rx queue drained", rx_q.size(), 0);

    // glitch shorter than half a period
    rx_src = 0; @(negedge clk); rx_src = 1;
    repeat (cur_p * 12) @(negedge clk);
    check("R8 glitch gives no char", rx_ready, 0);

    // framing error
    send_rx(32'h6D, 0, 0);
    repeat (cur_p * 2) @(negedge clk);
    check("R11 bad stop dropped", rx_ready, 0);

    // ready held until read, then cleared by disable
    auto_read = 0;
    send_rx(32'h77, 1, 0);
    check("R7 ready without read", rx_ready, 1);
    check("R7 data value", rx_data, 32'h77);
    held = rx_data;
    repeat (5) @(negedge clk);
    check("R9 ready holds", rx_ready, 1);
    check("R9 data holds", rx_data, held);
    en = 0;
    @(negedge clk);
    check("R10 disable clears ready", rx_ready, 0);
    check("R10 disable oe low", pin_oe, 0);
    auto_read = 1;

    repeat (10) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule